// File: doc/BRIEF.md
# Quadrature Tone Synthesizer with Single-Bus DAC Output

This block synthesizes a digital tone in quadrature and hands it to a DAC that has one data port. A wide phase register is stepped once per I/Q pair by a frequency word. Its upper bits address a quarter-wave sine table, which is folded out to a full period. The in-phase sample reads the table a quarter turn ahead of the phase, which gives a cosine. The quadrature sample reads it at the phase itself.

The two samples of each pair share one bus, one value per clock. The sequencer lines them up so that the first value seen in the cycle where the delayed transmit-enable goes high is always an I sample. Holding the frequency word constant gives a fixed tone. Changing it every pair gives frequency modulation.

Top module: `dds_iq_dac`

## Requirements
- R1: While `rst_n` is low at a clock edge, `dac_data` and `dac_tx_en` become 0. The phase register returns to 0, and the next sample after reset is an I sample.
- R2: `dac_tx_en` equals `tx_en` delayed by exactly two clocks.
- R3: In every cycle where `dac_tx_en` is 0, `dac_data` is 0.
- R4: In the first cycle where `dac_tx_en` is high, `dac_data` carries an I sample. Within a run of high cycles, the values then alternate Q, I, Q, and so on.
- R5: With k the top 10 bits of the pair's phase, the I sample is S((k+256) mod 1024) and the Q sample is S(k). Both appear on `dac_data` as 16-bit two's complement.
- R6: The I sample and the Q sample of one pair use the same phase. The phase for the next pair is the current phase plus the `ftw` value sampled in the I-slot cycle of the current pair. A zero word holds the phase constant.
- R7: The phase register is 32 bits wide and wraps modulo 2^32, so a step of 0xFFC00000 moves k back by one.
- R8: While `tx_en` is low, the phase holds and the slot returns to I. A pair cut short after its I slot does not advance the phase, so a later run restarts from the same phase.
- R9: `ftw` is ignored in Q-slot cycles and in cycles where `tx_en` is low.
- R10: S(j) is built from a quarter period. For m = j mod 256 and quadrant q = j div 256, the magnitude is round(32767·sin(2π·m'/1024)), where m' = m for even q and m' = 256−m for odd q. The value is negated for q ≥ 2. The peak values are +32767 and −32767, and the code 0x8000 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DAC sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmit request; high cycles produce samples |
| ftw | input | 32 | Frequency tuning word, sampled in the I-slot cycle |
| dac_data | output | 16 | Interleaved I/Q sample bus |
| dac_tx_en | output | 1 | Transmit-enable to the DAC, aligned with the first I sample |

## Verification
The bench goes after the pair boundary in several ways.

- **Word sampled in the wrong slot.** The bench drives an unrelated frequency word in every Q slot. A design that latched the word in the wrong slot, or that advanced the phase between I and Q, would emit a Q sample from a different phase than its I.
- **Cut-short pairs.** One-cycle and odd-length transmit bursts check that a half pair leaves the phase untouched and that the next burst opens with I. A design that kept the slot toggle across idle gaps would start a burst with Q.
- **Full table and quadrant folding.** A burst that steps k by one through all 1024 table positions exposes any error in the quarter-wave mirroring or in the sign at a quadrant boundary.
- **Wrap-around.** A step of a quarter turn and a negative step check that the phase wraps.
- **Latency and reset.** A mid-run reset checks that the phase restarts from zero. The enable and data latencies are checked to match exactly, which catches any skew between the enable and the first I sample.

// File: rtl/dds_pkg.sv
// Shared types and elaboration-time helpers for the quadrature tone synthesizer.
// Assumes: the sine helper is called only with constant arguments (table build).
package dds_pkg;

    // Which half of an I/Q pair the current bus cycle carries.
    typedef enum logic {
        SLOT_I = 1'b0,
        SLOT_Q = 1'b1
    } slot_e;

    // Rounded magnitude of amp*sin(2*pi*idx/(4*qn)) for idx in 0..qn (first quadrant).
    function automatic int quarter_sine(input int idx, input int qn, input int amp);
        real ang;
        real val;
        ang = 2.0 * 3.14159265358979323846 * real'(idx) / real'(4 * qn);
        val = real'(amp) * $sin(ang);
        return $rtoi(val + 0.5);
    endfunction

endpackage

// File: rtl/dds_iq_sequencer.sv
// Slot sequencer: tracks whether the current cycle is the I or the Q half of a pair,
// and delays transmit-enable by the lookup latency so it stays aligned with the data.
// Assumes: DELAY is at least 2 and equals the lookup latency.
module dds_iq_sequencer
    import dds_pkg::*;
#(
    parameter int DELAY = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tx_en,
    output slot_e slot,
    output logic  tx_en_dly
);
    localparam int LAST = DELAY - 1;

    slot_e slot_r;
    logic  en_sr   [DELAY];
    slot_e slot_sr [DELAY];

    // Toggle the slot each enabled cycle; fall back to I whenever transmit is idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            slot_r <= SLOT_I;
        end else begin
            slot_r <= (slot_r == SLOT_I) ? SLOT_Q : SLOT_I;
        end
    end

    // Carry enable and slot tag down the same number of stages as the data path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DELAY; i++) begin
                en_sr[i]   <= 1'b0;
                slot_sr[i] <= SLOT_I;
            end
        end else begin
            en_sr[0]   <= tx_en;
            slot_sr[0] <= slot_r;
            for (int i = 1; i < DELAY; i++) begin
                en_sr[i]   <= en_sr[i-1];
                slot_sr[i] <= slot_sr[i-1];
            end
        end
    end

    assign slot      = slot_r;
    assign tx_en_dly = en_sr[LAST];

    AST_FIRST_IS_I: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_sr[LAST]) |-> slot_sr[LAST] == SLOT_I); // R4
    AST_SLOTS_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_sr[LAST] && $past(en_sr[LAST])) |-> slot_sr[LAST] != $past(slot_sr[LAST])); // R4

    initial begin
        AST_DELAY_MIN: assert (DELAY >= 2); // R2
    end
endmodule

// File: rtl/dds_phase_acc.sv
// Phase accumulator: latches the tuning word on the I slot and adds it on the Q slot,
// so both halves of a pair see one phase. Holds while transmit is idle.
// Assumes: slot comes from the sequencer and is I on the first enabled cycle.
module dds_phase_acc
    import dds_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  slot_e             slot,
    input  logic [PHASE_W-1:0] ftw,
    output logic [ADDR_W-1:0]  phase_top
);
    logic [PHASE_W-1:0] acc;
    logic [PHASE_W-1:0] inc_r;

    // Capture the tuning word only in the I-slot cycle of a pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_r <= '0;
        end else if (en && slot == SLOT_I) begin
            inc_r <= ftw;
        end
    end

    // Advance the phase once per pair, after the Q half has used it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (en && slot == SLOT_Q) begin
            acc <= acc + inc_r;
        end
    end

    assign phase_top = acc[PHASE_W-1 -: ADDR_W];

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(acc)); // R8
    AST_PAIR_SAME_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && slot == SLOT_Q) |-> $stable(phase_top)); // R6
endmodule

// File: rtl/dds_quad_lookup.sv
// Two-stage quadrature lookup: stage 1 picks the table address (cosine is a quarter
// turn ahead), stage 2 folds a quarter-wave table into a full period and registers it.
// Assumes: ADDR_W >= 3; output amplitude is symmetric (most negative code unused).
module dds_quad_lookup
    import dds_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  slot_e                    slot,
    input  logic [ADDR_W-1:0]        phase_top,
    output logic signed [DATA_W-1:0] sample
);
    localparam int QN     = 1 << (ADDR_W - 2);
    localparam int QIDX_W = ADDR_W - 1;
    localparam int AMP    = (1 << (DATA_W - 1)) - 1;
    localparam logic [ADDR_W-1:0] QUARTER = ADDR_W'(QN);
    localparam logic [DATA_W-1:0] MIN_CODE = {1'b1, {(DATA_W-1){1'b0}}};

    logic signed [DATA_W-1:0] qtab [QN+1];
    logic                     en_r;
    logic [ADDR_W-1:0]        addr_r;
    logic [1:0]               quad;
    logic [ADDR_W-3:0]        fine;
    logic [QIDX_W-1:0]        tidx;
    logic signed [DATA_W-1:0] mag;
    logic signed [DATA_W-1:0] value;

    // Quarter-wave table, entries 0..QN inclusive so the peak is stored directly.
    for (genvar g = 0; g <= QN; g++) begin : g_qtab
        assign qtab[g] = DATA_W'(quarter_sine(g, QN, AMP));
    end

    // Stage 1: register the address, offset by a quarter turn for the I sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_r   <= 1'b0;
            addr_r <= '0;
        end else begin
            en_r   <= en;
            addr_r <= (slot == SLOT_I) ? phase_top + QUARTER : phase_top;
        end
    end

    // Fold the full-period address onto the quarter table and apply the sign.
    always_comb begin
        quad  = addr_r[ADDR_W-1 -: 2];
        fine  = addr_r[ADDR_W-3:0];
        tidx  = quad[0] ? QIDX_W'(QN) - QIDX_W'(fine) : QIDX_W'(fine);
        mag   = qtab[tidx];
        value = quad[1] ? -mag : mag;
    end

    // Stage 2: register the sample, forcing zero when this slot was not enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample <= '0;
        end else begin
            sample <= en_r ? value : '0;
        end
    end

    AST_NO_MIN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        sample != MIN_CODE); // R10
    AST_PEAK_AT_QUARTER: assert property (@(posedge clk) disable iff (!rst_n)
        (en_r && addr_r == QUARTER) |=> sample == DATA_W'(AMP)); // R10
endmodule

// File: rtl/dds_iq_dac.sv
// Top: quadrature tone synthesizer feeding a single-port DAC with interleaved I/Q.
// The phase advances once per pair; data and the delayed enable share a two-clock latency.
// Assumes: clk is the DAC sample clock; reset is synchronous and active low.
module dds_iq_dac
    import dds_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_en,
    input  logic [PHASE_W-1:0] ftw,
    output logic [DATA_W-1:0]  dac_data,
    output logic               dac_tx_en
);
    localparam int LOOKUP_LAT = 2;

    slot_e                    slot;
    logic [ADDR_W-1:0]        phase_top;
    logic signed [DATA_W-1:0] sample;
    logic [1:0]               warm_cnt;

    dds_iq_sequencer #(
        .DELAY (LOOKUP_LAT)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .slot      (slot),
        .tx_en_dly (dac_tx_en)
    );

    dds_phase_acc #(
        .PHASE_W (PHASE_W),
        .ADDR_W  (ADDR_W)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (tx_en),
        .slot      (slot),
        .ftw       (ftw),
        .phase_top (phase_top)
    );

    dds_quad_lookup #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_lut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (tx_en),
        .slot      (slot),
        .phase_top (phase_top),
        .sample    (sample)
    );

    assign dac_data = sample;

    // Count edges since reset so latency checks never look back into reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_cnt <= '0;
        end else if (warm_cnt != 2'd2) begin
            warm_cnt <= warm_cnt + 2'd1;
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_tx_en |-> dac_data == '0); // R3
    AST_TXEN_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_cnt == 2'd2) |-> dac_tx_en == $past(tx_en, 2)); // R2
endmodule

// File: tb/tb_dds_iq_dac.sv
// Bench: a vector table of (tuning word, pair count) bursts walked by one loop, then
// directed tests for reset, cut-short pairs, slot sampling and FM stepping.
module tb_dds_iq_dac;
    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0;
    logic [31:0] ftw = '0;
    logic [15:0] dac_data;
    logic        dac_tx_en;

    int checks = 0;
    int fails  = 0;

    // Bench-side model state.
    logic [31:0] m_phase = '0;
    logic [31:0] m_inc   = '0;
    bit          m_slot  = 1'b0;
    bit          pe_en  [2];
    int          pe_dat [2];
    string       pe_tag [2];
    bit          track = 1'b0;
    int          seen_max = -100000;
    int          seen_min = 100000;

    // {tuning word, pair count}
    localparam logic [47:0] VEC [6] = '{
        {32'h0040_0000, 16'd1024},
        {32'h4000_0000, 16'd6},
        {32'h0123_4567, 16'd20},
        {32'hFFC0_0000, 16'd8},
        {32'h0000_0000, 16'd4},
        {32'h8000_0000, 16'd4}
    };
    string row_tag [6] = '{"R10", "R7", "R6", "R7", "R6", "R5"};

    dds_iq_dac dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .ftw       (ftw),
        .dac_data  (dac_data),
        .dac_tx_en (dac_tx_en)
    );

    always #(CLK_NS/2) clk = ~clk;

    // Reference sine built from the stated quarter-wave rule.
    function automatic int s_val(input int k);
        int  quad;
        int  m;
        int  mm;
        real r;
        quad = k / 256;
        m    = k % 256;
        mm   = (quad % 2 == 1) ? 256 - m : m;
        r    = 32767.0 * $sin(2.0 * 3.14159265358979323846 * real'(mm) / 1024.0);
        mm   = $rtoi(r + 0.5);
        return (quad >= 2) ? -mm : mm;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One bus cycle: compare outputs due now, predict the new input's result, drive it.
    task automatic step(input bit en, input logic [31:0] f, input string tag);
        int k;
        int dat;
        int act;
        @(negedge clk);
        act = int'($signed(dac_data));
        check(dac_tx_en == pe_en[1], "R2", int'(dac_tx_en), int'(pe_en[1]), "dac_tx_en");
        check(act == pe_dat[1], pe_tag[1], act, pe_dat[1], "dac_data");
        if (track && pe_en[1]) begin
            if (act > seen_max) seen_max = act;
            if (act < seen_min) seen_min = act;
        end
        k = int'(m_phase[31:22]);
        if (!en) begin
            dat    = 0;
            m_slot = 1'b0;
        end else if (!m_slot) begin
            dat    = s_val((k + 256) % 1024);
            m_inc  = f;
            m_slot = 1'b1;
        end else begin
            dat     = s_val(k);
            m_phase = m_phase + m_inc;
            m_slot  = 1'b0;
        end
        pe_en[1]  = pe_en[0];
        pe_dat[1] = pe_dat[0];
        pe_tag[1] = pe_tag[0];
        pe_en[0]  = en;
        pe_dat[0] = dat;
        pe_tag[0] = en ? tag : "R3";
        tx_en = en;
        ftw   = f;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 32'h0, "R3");
    endtask

    task automatic burst(input logic [31:0] f, input int pairs, input string tag);
        for (int i = 0; i < 2 * pairs; i++) step(1'b1, f, (i == 0) ? "R4" : tag);
        idle(3);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tx_en = 1'b1;
        ftw   = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check(dac_data == '0, "R1", int'(dac_data), 0, "dac_data in reset");
        check(dac_tx_en == 1'b0, "R1", int'(dac_tx_en), 0, "dac_tx_en in reset");
        rst_n   = 1'b1;
        tx_en   = 1'b0;
        ftw     = '0;
        m_phase = '0;
        m_inc   = '0;
        m_slot  = 1'b0;
        for (int i = 0; i < 2; i++) begin
            pe_en[i]  = 1'b0;
            pe_dat[i] = 0;
            pe_tag[i] = "R1";
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        fails++;
        checks++;
        $display("FAIL R2 watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        do_reset();
        idle(2);

        // Vector table walk.
        for (int r = 0; r < 6; r++) begin
            track = (r == 0);
            burst(VEC[r][47:16], int'(VEC[r][15:0]), row_tag[r]);
            track = 1'b0;
            if (r == 0) begin
                check(seen_max == 32767, "R10", seen_max, 32767, "sweep maximum");
                check(seen_min == -32767, "R10", seen_min, -32767, "sweep minimum");
            end
        end

        // R8: a single I-only cycle must not advance the phase; the next burst starts on I.
        step(1'b1, 32'h1000_0000, "R8");
        idle(3);
        burst(32'h0300_0000, 3, "R8");
        // R8: odd-length burst leaves a dangling I.
        for (int i = 0; i < 5; i++) step(1'b1, 32'h0500_0000, "R8");
        idle(4);
        burst(32'h0500_0000, 2, "R8");

        // R9: garbage word during Q slots and idle cycles must have no effect.
        for (int i = 0; i < 20; i++)
            step(1'b1, (i % 2 == 0) ? 32'h0200_0000 : 32'hDEAD_BEEF, "R9");
        for (int i = 0; i < 3; i++) step(1'b0, 32'h7777_7777, "R9");
        burst(32'h0200_0000, 2, "R9");

        // R6: FM stepping, a new word every pair.
        for (int i = 0; i < 16; i++) begin
            step(1'b1, 32'(i) * 32'h0110_0000, "R6");
            step(1'b1, 32'h0, "R6");
        end
        idle(3);

        // R1: reset mid-run returns the phase to zero.
        burst(32'h0987_6543, 5, "R5");
        do_reset();
        idle(1);
        burst(32'h0080_0000, 4, "R1");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule